// File: doc/BRIEF.md
# Synchronous Serial Burst Shifter

This block is a clocked serial port. It moves a programmed number of bits, anywhere from 1 to 256, in one uninterrupted run with no help from the host between bytes. The host sets the bit order, the serial clock divider and the bit count, places the first byte on `tx_byte`, and pulses `start`. The port then produces its own serial clock. It shifts data out on falling edges and samples `sdi` on rising edges. At every byte boundary it takes the next byte from `tx_byte` and hands the received byte back on `rx_byte`.

The host supplies bytes in response to the `byte_req` pulse, which marks the cycle in which the current `tx_byte` value was taken. The host can ask the port to hold with `suspend_req`. The port then stops only when the current byte is complete. It parks the serial clock high and waits for `resume`. When the count runs out, `done` rises and `busy` falls together. The half period of the serial clock is `cfg_div + 1` system cycles, so a full period spans 2 to 512 cycles. This covers a fast-to-slow range of 1:256.

Top module: `ssp_burst`

## Requirements
- R1: After reset and while idle, `sck` and `sdo` are 1, and `busy`, `done`, `paused`, `byte_req` and `rx_valid` are 0.
- R2: A `start` pulse seen at a clock edge while idle makes `sck` 0 and `busy` 1 from the next cycle. Each low phase and each high phase of `sck` then lasts `cfg_div + 1` cycles, using the divider value captured at start.
- R3: With `cfg_msb_first` = 1, every byte goes out bit 7 first. With 0, it goes out bit 0 first. The order is captured at start and holds for the whole transfer, even if the input changes later.
- R4: During a transfer, `sdo` changes only in the cycle where `sck` falls. `sdi` is sampled at the clock edge where `sck` rises.
- R5: A transfer moves exactly `cfg_bits_m1 + 1` bits, captured at start (0 means 1 bit, 255 means 256 bits).
- R6: When a byte ends and more bits remain, the next byte is taken from `tx_byte` in the same cycle that `sck` falls. `byte_req` pulses for that one cycle. The byte captured at start also gives a `byte_req` pulse.
- R7: Each completed byte, and the final byte, appear on `rx_byte` with a one-cycle `rx_valid` pulse. The earliest received bit sits highest when MSB-first and lowest when LSB-first. A final partial byte of k bits is right-justified in `rx_byte[k-1:0]` when MSB-first and left-justified in `rx_byte[7:8-k]` when LSB-first. All other bits are 0.
- R8: When the last high phase ends, `done` becomes 1 and `busy` becomes 0 in the same cycle, and `sck` stays 1. `done` holds until the next start.
- R9: A `suspend_req` pulse during a byte lets that byte finish, then the port holds. While holding, `sck` is 1, `paused` is 1 and `busy` stays 1.
- R10: A `resume` pulse while paused restarts the port on the next cycle. It takes the next byte with `byte_req` and drives `sck` low.
- R11: A `start` pulse while a transfer is running has no effect.
- R12: If a suspend is pending when the final bit completes, the transfer ends with `done` and does not pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_msb_first | input | 1 | Bit order: 1 = bit 7 first, 0 = bit 0 first |
| cfg_div | input | 8 | Serial clock half period minus one, in system cycles |
| cfg_bits_m1 | input | 8 | Number of bits in the transfer minus one |
| start | input | 1 | Begin a transfer (ignored while busy) |
| suspend_req | input | 1 | Ask to hold at the next byte boundary |
| resume | input | 1 | Continue after a hold |
| tx_byte | input | 8 | Next byte to transmit |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress, including holds |
| done | output | 1 | Count exhausted, held until next start |
| paused | output | 1 | Holding at a byte boundary |
| byte_req | output | 1 | One-cycle pulse when `tx_byte` was taken |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` updates |

## Verification
The hardest situations to reach are the interactions at a byte boundary. These include a suspend that lands on the final full byte, a hold followed by a resume that must bring in a byte queued long before, and a final partial byte whose justification depends on the bit order. The bench drives whole transfers from a behavioural model that predicts every cycle from the bit index and the divider. It places `suspend_req` at chosen bytes, including the last one, and flips `cfg_msb_first` and pulses `start` in mid-transfer. It uses bit counts of 1, 13, 21 and 256 to cover partial, single-bit and maximum runs.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_PAUSE = 2'd3
    } ssp_state_e;

    typedef logic [BYTE_W-1:0] byte_t;

    // bit presented first on the line for a given order
    function automatic logic head_bit(input byte_t d, input logic msb);
        return msb ? d[BYTE_W-1] : d[0];
    endfunction

    // move the outgoing register by one position
    function automatic byte_t tx_advance(input byte_t d, input logic msb);
        return msb ? {d[BYTE_W-2:0], 1'b0} : {1'b0, d[BYTE_W-1:1]};
    endfunction

    // accumulate one received bit
    function automatic byte_t rx_accum(input byte_t d, input logic b, input logic msb);
        return msb ? {d[BYTE_W-2:0], b} : {b, d[BYTE_W-1:1]};
    endfunction

endpackage

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;

    assign tick = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            div_q <= '0;
        end else if (restart) begin
            cnt   <= div;
            div_q <= div;
        end else if (run) begin
            if (cnt == '0) cnt <= div_q;
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ssp_bitcount.sv
module ssp_bitcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] bits_m1,
    input  logic             step,
    output logic             last,
    output logic             byte_end
);
    import ssp_pkg::*;

    logic [CNT_W-1:0] remain;
    logic [IDX_W-1:0] idx;

    assign last     = (remain == '0);
    assign byte_end = (idx == IDX_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            idx    <= '0;
        end else if (load) begin
            remain <= bits_m1;
            idx    <= '0;
        end else if (step) begin
            remain <= remain - 1'b1;
            idx    <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter (
    input  logic          clk,
    input  logic          rst,
    input  logic          msb,
    input  logic          load,
    input  ssp_pkg::byte_t load_data,
    input  logic          advance,
    input  logic          sample,
    input  logic          sdi,
    output logic          next_head,
    output ssp_pkg::byte_t rx_sh
);
    import ssp_pkg::*;

    byte_t tx_sh;
    byte_t tx_moved;

    assign tx_moved  = tx_advance(tx_sh, msb);
    assign next_head = load ? head_bit(load_data, msb) : head_bit(tx_moved, msb);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (load)         tx_sh <= load_data;
            else if (advance) tx_sh <= tx_moved;

            if (load)         rx_sh <= '0;
            else if (sample)  rx_sh <= rx_accum(rx_sh, sdi, msb);
        end
    end
endmodule

// File: rtl/ssp_burst.sv
module ssp_burst #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_msb_first,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [CNT_W-1:0] cfg_bits_m1,
    input  logic             start,
    input  logic             suspend_req,
    input  logic             resume,
    input  logic [7:0]       tx_byte,
    input  logic             sdi,
    output logic             sck,
    output logic             sdo,
    output logic             busy,
    output logic             done,
    output logic             paused,
    output logic             byte_req,
    output logic [7:0]       rx_byte,
    output logic             rx_valid
);
    import ssp_pkg::*;

    ssp_state_e state;
    logic       msb_q;
    logic       susp_pend;
    logic       tick, last, byte_end, next_head;
    byte_t      rx_sh;

    logic start_ok, resume_ok, rise, high_end, finish, boundary;
    logic go_pause, new_byte, next_bit, msb_eff, running;

    assign running   = (state == ST_LOW) || (state == ST_HIGH);
    assign start_ok  = start  && (state == ST_IDLE);
    assign resume_ok = resume && (state == ST_PAUSE);
    assign rise      = (state == ST_LOW)  && tick;
    assign high_end  = (state == ST_HIGH) && tick;
    assign finish    = high_end && last;
    assign boundary  = high_end && !last && byte_end;
    assign go_pause  = boundary && susp_pend;
    assign next_bit  = high_end && !last && !byte_end;
    assign new_byte  = start_ok || resume_ok || (boundary && !susp_pend);
    assign msb_eff   = start_ok ? cfg_msb_first : msb_q;
    assign paused    = (state == ST_PAUSE);

    ssp_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (start_ok),
        .run     (running),
        .div     (cfg_div),
        .tick    (tick)
    );

    ssp_bitcount #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (start_ok),
        .bits_m1  (cfg_bits_m1),
        .step     (high_end && !last),
        .last     (last),
        .byte_end (byte_end)
    );

    ssp_shifter u_sh (
        .clk       (clk),
        .rst       (rst),
        .msb       (msb_eff),
        .load      (new_byte),
        .load_data (tx_byte),
        .advance   (next_bit),
        .sample    (rise),
        .sdi       (sdi),
        .next_head (next_head),
        .rx_sh     (rx_sh)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            msb_q     <= 1'b0;
            susp_pend <= 1'b0;
            sck       <= 1'b1;
            sdo       <= 1'b1;
            busy      <= 1'b0;
            done      <= 1'b0;
            byte_req  <= 1'b0;
            rx_byte   <= '0;
            rx_valid  <= 1'b0;
        end else begin
            byte_req <= new_byte;
            rx_valid <= finish || boundary;

            if (start_ok) msb_q <= cfg_msb_first;

            if (start_ok || go_pause || finish)
                susp_pend <= 1'b0;
            else if (suspend_req && running)
                susp_pend <= 1'b1;

            if (finish || boundary) rx_byte <= rx_sh;

            if (new_byte || next_bit) sdo <= next_head;
            else if (finish)          sdo <= 1'b1;

            if (start_ok) begin
                busy <= 1'b1;
                done <= 1'b0;
            end else if (finish) begin
                busy <= 1'b0;
                done <= 1'b1;
            end

            unique case (state)
                ST_IDLE: if (start_ok) begin
                    state <= ST_LOW;
                    sck   <= 1'b0;
                end
                ST_LOW: if (tick) begin
                    state <= ST_HIGH;
                    sck   <= 1'b1;
                end
                ST_HIGH: if (tick) begin
                    if (finish)        state <= ST_IDLE;
                    else if (go_pause) state <= ST_PAUSE;
                    else begin
                        state <= ST_LOW;
                        sck   <= 1'b0;
                    end
                end
                ST_PAUSE: if (resume_ok) begin
                    state <= ST_LOW;
                    sck   <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ssp_burst_chk.sv
module ssp_burst_chk (
    input logic clk,
    input logic rst,
    input logic sck,
    input logic sdo,
    input logic busy,
    input logic done,
    input logic paused,
    input logic byte_req
);
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_done_with_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (sck && $fell(busy)));

    a_r9_pause_clock_high: assert property (@(posedge clk) disable iff (rst)
        paused |-> (sck && busy));

    a_r4_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$fell(sck)) |-> $stable(sdo));

    a_r6_req_with_low_clock: assert property (@(posedge clk) disable iff (rst)
        byte_req |-> (!sck && busy));

    a_r1_idle_clock_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck);
endmodule

bind ssp_burst ssp_burst_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sck      (sck),
    .sdo      (sdo),
    .busy     (busy),
    .done     (done),
    .paused   (paused),
    .byte_req (byte_req)
);

// File: tb/ssp_burst_test.sv
module ssp_burst_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_msb_first;
    logic [7:0] cfg_div;
    logic [7:0] cfg_bits_m1;
    logic       start, suspend_req, resume;
    logic [7:0] tx_byte;
    logic       sdi;
    logic       sck, sdo, busy, done, paused, byte_req, rx_valid;
    logic [7:0] rx_byte;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] txd [0:33];

    always #5 clk = ~clk;

    ssp_burst uut (
        .clk(clk), .rst(rst), .cfg_msb_first(cfg_msb_first), .cfg_div(cfg_div),
        .cfg_bits_m1(cfg_bits_m1), .start(start), .suspend_req(suspend_req),
        .resume(resume), .tx_byte(tx_byte), .sdi(sdi), .sck(sck), .sdo(sdo),
        .busy(busy), .done(done), .paused(paused), .byte_req(byte_req),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    task automatic cmp(input logic [7:0] got, input logic [7:0] exp, input string what);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", what, got, exp, $time);
        end
    endtask

    task automatic step(input logic e_sck, input logic e_busy, input logic e_done,
                        input logic e_paused, input logic e_req, input logic e_rv,
                        input logic [7:0] e_rx, input logic chk_sdo, input logic e_sdo,
                        input string tag);
        cmp({7'd0, sck},      {7'd0, e_sck},    {tag, " R2 sck"});
        cmp({7'd0, busy},     {7'd0, e_busy},   {tag, " R8 busy"});
        cmp({7'd0, done},     {7'd0, e_done},   {tag, " R8 done"});
        cmp({7'd0, paused},   {7'd0, e_paused}, {tag, " R9 paused"});
        cmp({7'd0, byte_req}, {7'd0, e_req},    {tag, " R6 byte_req"});
        cmp({7'd0, rx_valid}, {7'd0, e_rv},     {tag, " R7 rx_valid"});
        if (e_rv)    cmp(rx_byte, e_rx, {tag, " R7 rx_byte"});
        if (chk_sdo) cmp({7'd0, sdo}, {7'd0, e_sdo}, {tag, " R3/R4 sdo"});
    endtask

    function automatic logic pat(input int b, input int seed);
        return ((b * 5 + seed) % 7) < 3;
    endfunction

    // one whole transfer, predicted cycle by cycle
    task automatic run(input int nbits, input bit msb, input int dv, input int susp_byte,
                       input int plen, input int start_mid, input int seed, input string tag);
        int   h = dv + 1;
        logic [7:0] acc = 8'd0;
        logic [7:0] rx_prev = 8'd0;
        bit   rv_pend = 0;
        for (int i = 0; i < 34; i++) txd[i] = 8'((i * 37 + seed * 11 + 5) & 255);
        cfg_msb_first = msb;
        cfg_div       = 8'(dv);
        cfg_bits_m1   = 8'(nbits - 1);
        tx_byte       = txd[0];
        start         = 1'b1;
        @(negedge clk);
        start         = 1'b0;
        cfg_msb_first = ~msb;          // R3: must not affect this transfer
        cfg_div       = 8'(dv + 3);
        cfg_bits_m1   = 8'(nbits + 4); // R5: captured at start
        for (int b = 0; b < nbits; b++) begin
            int   byt = b / 8;
            int   pos = b % 8;
            logic eb  = msb ? txd[byt][7 - pos] : txd[byt][pos];
            logic ib  = pat(b, seed);
            if (pos == 0) acc = 8'd0;
            for (int c = 0; c < h; c++) begin
                step(1'b0, 1'b1, 1'b0, 1'b0, (c == 0 && pos == 0),
                     (c == 0 && pos == 0 && rv_pend), rx_prev, 1'b1, eb, tag);
                if (c == 0 && pos == 0) begin
                    rv_pend = 0;
                    tx_byte = txd[byt + 1];
                end
                suspend_req = (c == 0 && pos == 0 && byt == susp_byte);
                start       = (c == 0 && b == start_mid);  // R11
                if (c == 0) sdi = ib;
                @(negedge clk);
            end
            acc = msb ? {acc[6:0], ib} : {ib, acc[7:1]};
            for (int c = 0; c < h; c++) begin
                step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 1'b1, eb, tag);
                suspend_req = 1'b0;
                start       = 1'b0;
                @(negedge clk);
            end
            if (pos == 7 && b != nbits - 1) begin
                rx_prev = acc;
                rv_pend = 1;
                if (byt == susp_byte) begin
                    // R9: hold after the byte, R10: resume
                    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, rx_prev, 1'b0, 1'b0, {tag, " R9"});
                    rv_pend = 0;
                    @(negedge clk);
                    for (int p = 0; p < plen; p++) begin
                        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, {tag, " R10"});
                        resume = (p == plen - 1);
                        @(negedge clk);
                    end
                    resume = 1'b0;
                end
            end
        end
        // R8/R12: completion, final byte justified per R7
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, acc, 1'b1, 1'b1, {tag, " R5 end"});
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, {tag, " R8 hold"});
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_msb_first = 1'b1; cfg_div = 8'd0; cfg_bits_m1 = 8'd7;
        start = 1'b0; suspend_req = 1'b0; resume = 1'b0; tx_byte = 8'd0; sdi = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, "R1 reset");
        cmp(rx_byte, 8'd0, "R1 rx_byte");
        run(8,   1'b1, 0,   99, 0, -1, 1, "t8_msb");
        run(13,  1'b0, 2,   99, 0, -1, 2, "t13_lsb_R7");
        run(21,  1'b1, 1,   1,  6, -1, 3, "t21_msb_susp");
        run(1,   1'b0, 0,   99, 0, -1, 4, "t1_lsb");
        run(256, 1'b1, 0,   3,  4, 40, 5, "t256_msb");
        run(16,  1'b0, 3,   1,  0, 5,  6, "t16_R12_R11");
        run(3,   1'b0, 255, 99, 0, -1, 7, "t3_slow");
        run(11,  1'b0, 0,   0,  1, -1, 8, "t11_lsb_susp");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule